// File: doc/BRIEF.md
# Real-Time Clock Periodic Interrupt and Half-Minute Adjust Controller

This block is the control section of a real-time clock that turns time-keeping strobes into periodic interrupt requests and carries out a half-minute rounding of the clock. The seconds, minutes and hours counters live outside it. They deliver a 1/64 s tick, a 1 Hz tick, a minute rollover strobe, a 1-hour rollover strobe and the current binary seconds count. A two-bit rate code picks which of the four strobes counts as the interrupt event. Each event sets a sticky request flag, which the host clears by writing 0 to it. The interrupt pin either follows that flag (latched mode) or gives a pulse of fixed width for every event (pulse mode). A mask bit holds the pin low in both modes.

The host starts an adjust by writing 1 to the adjust bit. In that cycle the block checks the seconds count. If it is 30 or more, it issues a one-cycle "clear seconds" strobe together with a "carry into minutes" strobe. Otherwise it issues only the "clear seconds" strobe. A window counter then runs on the system clock for a parameterised number of cycles (125 µs by default at 250 MHz). For the whole window the adjust bit reads back as 1 and host access to the time counters is refused. The counter only advances while the oscillator-running input is high. If the oscillator stops, the adjust bit never clears.

The register port is a single write strobe with a one-bit address and a data bus. Read data is combinational from the address.

Address 0 is the control register:
- bits 1:0: rate code
- bit 2: mask
- bit 3: pulse mode

Address 1 is the status register:
- bit 0: request flag
- bit 1: adjust bit

All other read bits are 0.

Top module: `rtc_irq_adjust`

## Requirements
- R1: While reset is asserted and after it is released, the control register, the request flag, the adjust bit, irqOut, cntBlocked, cntGrant, adjSecClear and adjMinCarry are all 0.
- R2: The rate code (control bits 1:0) selects the event source: 00 selects tick64, 01 selects tickSec, 10 selects minRoll and 11 selects hourRoll. A strobe that is not selected never sets the request flag.
- R3: A selected event sets the request flag (status bit 0) on the next clock edge. The flag stays set until a status write with bit 0 = 0. A status write with bit 0 = 1 leaves the flag unchanged.
- R4: A status write with bit 0 = 0 in the same cycle as a selected event leaves the flag cleared.
- R5: With control bit 3 = 0 (latched mode) and control bit 2 = 0, irqOut equals the request flag.
- R6: With control bit 3 = 1 (pulse mode) and control bit 2 = 0, every selected event drives irqOut high for exactly PULSE_CYCLES cycles, starting the cycle after the event. A new event restarts the pulse.
- R7: With control bit 2 = 1, irqOut stays 0, while the request flag still records events.
- R8: A status write with bit 1 = 1 while no adjust is running sets the adjust bit and cntBlocked. Both stay high for ADJ_CYCLES oscillator-running cycles and then fall to 0 together.
- R9: cntGrant is 1 only when cntReq is 1 and no adjust window is running.
- R10: Starting an adjust gives adjSecClear high for exactly one cycle, the cycle after the start write. adjMinCarry is high in that same cycle when secCount was 30 or more at the start write, and 0 otherwise.
- R11: While oscRun is 0, the adjust window counter holds, so the adjust bit and cntBlocked stay set.
- R12: A status write with bit 1 = 1 while an adjust window is running neither restarts nor lengthens the window and gives no new rounding strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick64 | input | 1 | 1/64 s strobe, one cycle wide |
| tickSec | input | 1 | 1 Hz strobe, one cycle wide |
| minRoll | input | 1 | Minute rollover strobe |
| hourRoll | input | 1 | Hour rollover strobe |
| oscRun | input | 1 | High while the oscillator is running |
| secCount | input | SEC_W | Current binary seconds count (0 to 59) |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 control, 1 status |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data of the addressed register |
| cntReq | input | 1 | Host request to access the time counters |
| cntGrant | output | 1 | Time-counter access granted |
| cntBlocked | output | 1 | Adjust window running, counter access refused |
| irqOut | output | 1 | Interrupt output, active high |
| adjSecClear | output | 1 | One-cycle strobe: clear seconds to 00 |
| adjMinCarry | output | 1 | One-cycle strobe: add one minute |

## Verification
Each of the four rate codes is run while all four strobes are pulsed one by one. This shows the selected source apart from its three neighbours and shows that the flag ignores the others. The clear is tried in a quiet cycle, in the same cycle as an event and with bit 0 = 1, to separate clearing, clear priority and a write that must do nothing. Events in latched mode, pulse mode (single events and back-to-back events) and masked mode tell the pin modes apart. Adjusts are started with seconds of 45, 30, 29 and 12 to bracket the rounding threshold. They are also started with a second start write during the window and with the oscillator paused, to separate the window length from a restart or a freeze.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

  // Register select
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  // Control register bit positions
  localparam int CTRL_RATE_LO = 0;
  localparam int CTRL_RATE_HI = 1;
  localparam int CTRL_MASK    = 2;
  localparam int CTRL_PULSE   = 3;
  localparam int CTRL_W       = 4;

  // Status register bit positions
  localparam int STAT_FLAG = 0;
  localparam int STAT_ADJ  = 1;

  typedef enum logic [1:0] {
    RATE_FAST = 2'b00,
    RATE_SEC  = 2'b01,
    RATE_MIN  = 2'b10,
    RATE_HOUR = 2'b11
  } rate_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic              ctrlLoad;
    logic [CTRL_W-1:0] ctrlData;
    logic              flagSet;
    logic              flagClr;
    logic              adjStart;
    logic              roundUp;
  } ctrl_strobe_t;

endpackage

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SEC_W    = 6,
  parameter int HALF_MIN = 30
) (
  input  logic              wrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tick64,
  input  logic              tickSec,
  input  logic              minRoll,
  input  logic              hourRoll,
  input  logic [SEC_W-1:0]  secCount,
  input  rate_e             rateSel,
  input  logic              adjBusy,
  output ctrl_strobe_t      strb
);

  localparam int NUM_SRC = 4;
  localparam logic [SEC_W-1:0] HALF_VAL = SEC_W'(HALF_MIN);

  logic [NUM_SRC-1:0] srcVec;
  logic               ctrlWrite;
  logic               statWrite;

  always_comb begin
    srcVec[RATE_FAST] = tick64;
    srcVec[RATE_SEC]  = tickSec;
    srcVec[RATE_MIN]  = minRoll;
    srcVec[RATE_HOUR] = hourRoll;
  end

  assign ctrlWrite = wrEn && (regAddr == ADDR_CTRL);
  assign statWrite = wrEn && (regAddr == ADDR_STAT);

  always_comb begin
    strb          = '0;
    strb.ctrlLoad = ctrlWrite;
    strb.ctrlData = wrData[CTRL_W-1:0];
    strb.flagSet  = srcVec[rateSel];
    strb.flagClr  = statWrite && !wrData[STAT_FLAG];
    strb.adjStart = statWrite && wrData[STAT_ADJ] && !adjBusy;
    strb.roundUp  = strb.adjStart && (secCount >= HALF_VAL);
  end

endmodule

// File: rtl/rtc_irq_dpath.sv
module rtc_irq_dpath
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int ADJ_CYCLES   = 31250,
  parameter int PULSE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strb,
  input  logic              oscRun,
  input  logic              regAddr,
  input  logic              cntReq,
  output rate_e             rateSel,
  output logic              adjBusy,
  output logic              irqFlag,
  output logic              maskBit,
  output logic              irqOut,
  output logic              cntGrant,
  output logic              adjSecClear,
  output logic              adjMinCarry,
  output logic [DATA_W-1:0] rdData
);

  localparam int BUSY_W  = $clog2(ADJ_CYCLES + 1);
  localparam int PULSE_W = $clog2(PULSE_CYCLES + 1);

  logic [CTRL_W-1:0] ctrlReg;
  logic [BUSY_W-1:0] busyCnt;
  logic              pulseActive;

  // Control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ctrlReg <= '0;
    else if (strb.ctrlLoad) ctrlReg <= strb.ctrlData;
  end

  assign rateSel = rate_e'(ctrlReg[CTRL_RATE_HI:CTRL_RATE_LO]);
  assign maskBit = ctrlReg[CTRL_MASK];

  // Sticky request flag, clear wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             irqFlag <= 1'b0;
    else if (strb.flagClr) irqFlag <= 1'b0;
    else if (strb.flagSet) irqFlag <= 1'b1;
  end

  // Pulse generator: counter or single flop depending on width
  generate
    if (PULSE_CYCLES > 1) begin : g_pulseCnt
      logic [PULSE_W-1:0] pulseCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              pulseCnt <= '0;
        else if (strb.flagSet)  pulseCnt <= PULSE_W'(PULSE_CYCLES);
        else if (pulseCnt != 0) pulseCnt <= pulseCnt - 1'b1;
      end
      assign pulseActive = (pulseCnt != 0);
    end else begin : g_pulseFlop
      logic pulseQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pulseQ <= 1'b0;
        else       pulseQ <= strb.flagSet;
      end
      assign pulseActive = pulseQ;
    end
  endgenerate

  always_comb begin
    if (maskBit)                  irqOut = 1'b0;
    else if (ctrlReg[CTRL_PULSE]) irqOut = pulseActive;
    else                          irqOut = irqFlag;
  end

  // Adjust window counter, frozen while oscillator stopped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        busyCnt <= '0;
    else if (strb.adjStart)           busyCnt <= BUSY_W'(ADJ_CYCLES);
    else if (busyCnt != 0 && oscRun)  busyCnt <= busyCnt - 1'b1;
  end

  assign adjBusy  = (busyCnt != 0);
  assign cntGrant = cntReq && !adjBusy;

  // Rounding strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adjSecClear <= 1'b0;
      adjMinCarry <= 1'b0;
    end else begin
      adjSecClear <= strb.adjStart;
      adjMinCarry <= strb.roundUp;
    end
  end

  // Read mux
  always_comb begin
    rdData = '0;
    if (regAddr == ADDR_CTRL) begin
      rdData[CTRL_W-1:0] = ctrlReg;
    end else begin
      rdData[STAT_FLAG] = irqFlag;
      rdData[STAT_ADJ]  = adjBusy;
    end
  end

endmodule

// File: rtl/rtc_irq_adjust.sv
module rtc_irq_adjust
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SEC_W        = 6,
  parameter int HALF_MIN     = 30,
  parameter int ADJ_CYCLES   = 31250,
  parameter int PULSE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick64,
  input  logic              tickSec,
  input  logic              minRoll,
  input  logic              hourRoll,
  input  logic              oscRun,
  input  logic [SEC_W-1:0]  secCount,
  input  logic              wrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              cntReq,
  output logic              cntGrant,
  output logic              cntBlocked,
  output logic              irqOut,
  output logic              adjSecClear,
  output logic              adjMinCarry
);

  ctrl_strobe_t strb;
  rate_e        rateSel;
  logic         adjBusy;
  logic         irqFlag;
  logic         maskBit;

  rtc_irq_ctrl #(
    .DATA_W  (DATA_W),
    .SEC_W   (SEC_W),
    .HALF_MIN(HALF_MIN)
  ) u_ctrl (
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .wrData  (wrData),
    .tick64  (tick64),
    .tickSec (tickSec),
    .minRoll (minRoll),
    .hourRoll(hourRoll),
    .secCount(secCount),
    .rateSel (rateSel),
    .adjBusy (adjBusy),
    .strb    (strb)
  );

  rtc_irq_dpath #(
    .DATA_W      (DATA_W),
    .ADJ_CYCLES  (ADJ_CYCLES),
    .PULSE_CYCLES(PULSE_CYCLES)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .oscRun     (oscRun),
    .regAddr    (regAddr),
    .cntReq     (cntReq),
    .rateSel    (rateSel),
    .adjBusy    (adjBusy),
    .irqFlag    (irqFlag),
    .maskBit    (maskBit),
    .irqOut     (irqOut),
    .cntGrant   (cntGrant),
    .adjSecClear(adjSecClear),
    .adjMinCarry(adjMinCarry),
    .rdData     (rdData)
  );

  assign cntBlocked = adjBusy;

endmodule

// File: rtl/rtc_irq_checker.sv
module rtc_irq_checker
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              regAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              oscRun,
  input logic              cntReq,
  input logic              cntGrant,
  input logic              cntBlocked,
  input logic              irqOut,
  input logic              irqFlag,
  input logic              maskBit,
  input logic              adjSecClear,
  input logic              adjMinCarry
);

  logic statWr;
  assign statWr = wrEn && (regAddr == ADDR_STAT);

  assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    statWr && !wrData[STAT_FLAG] |=> !irqFlag);

  assert_mask_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    maskBit |-> !irqOut);

  assert_grant_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    cntGrant |-> (cntReq && !cntBlocked));

  assert_start_window_R8: assert property (@(posedge clk) disable iff (!rstN)
    statWr && wrData[STAT_ADJ] && !cntBlocked |=> cntBlocked && adjSecClear);

  assert_carry_paired_R10: assert property (@(posedge clk) disable iff (!rstN)
    adjMinCarry |-> adjSecClear);

  assert_osc_freeze_R11: assert property (@(posedge clk) disable iff (!rstN)
    cntBlocked && !oscRun |=> cntBlocked);

  assert_no_restart_R12: assert property (@(posedge clk) disable iff (!rstN)
    cntBlocked && $past(cntBlocked) |-> !adjSecClear);

endmodule

bind rtc_irq_adjust rtc_irq_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .regAddr    (regAddr),
  .wrData     (wrData),
  .oscRun     (oscRun),
  .cntReq     (cntReq),
  .cntGrant   (cntGrant),
  .cntBlocked (cntBlocked),
  .irqOut     (irqOut),
  .irqFlag    (irqFlag),
  .maskBit    (maskBit),
  .adjSecClear(adjSecClear),
  .adjMinCarry(adjMinCarry)
);

// File: tb/rtc_irq_adjust_test.sv
`timescale 1ns/1ps
module rtc_irq_adjust_test;

  localparam int DW    = 8;
  localparam int SW    = 6;
  localparam int ADJ   = 40;
  localparam int PULSE = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick64 = 0, tickSec = 0, minRoll = 0, hourRoll = 0;
  logic oscRun = 1'b1;
  logic [SW-1:0] secCount = '0;
  logic wrEn = 0, regAddr = 1'b1;
  logic [DW-1:0] wrData = '0;
  logic cntReq = 1'b0;
  logic [DW-1:0] rdData;
  logic cntGrant, cntBlocked, irqOut, adjSecClear, adjMinCarry;

  always #2 clk = ~clk;

  rtc_irq_adjust #(
    .DATA_W(DW), .SEC_W(SW), .HALF_MIN(30),
    .ADJ_CYCLES(ADJ), .PULSE_CYCLES(PULSE)
  ) uut (
    .clk(clk), .rstN(rstN), .tick64(tick64), .tickSec(tickSec),
    .minRoll(minRoll), .hourRoll(hourRoll), .oscRun(oscRun),
    .secCount(secCount), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .cntReq(cntReq), .cntGrant(cntGrant),
    .cntBlocked(cntBlocked), .irqOut(irqOut),
    .adjSecClear(adjSecClear), .adjMinCarry(adjMinCarry)
  );

  // Behavioural reference state
  int mCtrl = 0, mFlag = 0, mPulse = 0, mBusy = 0, mSecClr = 0, mCarry = 0;
  bit started = 0;
  bit done = 0;
  int nVec = 0, nFail = 0, cycles = 0;
  string curReq = "R1";

  always @(posedge clk) begin
    int evt;
    int clr, start;
    cycles++;
    if (!rstN) begin
      mCtrl = 0; mFlag = 0; mPulse = 0; mBusy = 0; mSecClr = 0; mCarry = 0;
    end else begin
      case (mCtrl % 4)
        0: evt = tick64;
        1: evt = tickSec;
        2: evt = minRoll;
        default: evt = hourRoll;
      endcase
      clr   = (wrEn && regAddr && !wrData[0]) ? 1 : 0;
      start = (wrEn && regAddr && wrData[1] && mBusy == 0) ? 1 : 0;
      if (clr != 0) mFlag = 0;
      else if (evt != 0) mFlag = 1;
      if (evt != 0) mPulse = PULSE;
      else if (mPulse > 0) mPulse--;
      if (start != 0) mBusy = ADJ;
      else if (mBusy > 0 && oscRun) mBusy--;
      mSecClr = start;
      mCarry  = (start != 0 && secCount >= 30) ? 1 : 0;
      if (wrEn && !regAddr) mCtrl = wrData[3:0];
    end
    started = 1;
  end

  task automatic cmp(string what, int act, int exp);
    nVec++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", curReq, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int eIrq, eRd;
    if (started && !done) begin
      if ((mCtrl & 4) != 0) eIrq = 0;
      else if ((mCtrl & 8) != 0) eIrq = (mPulse > 0) ? 1 : 0;
      else eIrq = mFlag;
      eRd = regAddr ? (mFlag + ((mBusy > 0) ? 2 : 0)) : mCtrl;
      cmp("irqOut", irqOut, eIrq);
      cmp("rdData", rdData, eRd);
      cmp("cntBlocked", cntBlocked, (mBusy > 0) ? 1 : 0);
      cmp("cntGrant", cntGrant, (cntReq && mBusy == 0) ? 1 : 0);
      cmp("adjSecClear", adjSecClear, mSecClr);
      cmp("adjMinCarry", adjMinCarry, mCarry);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      wrEn = 0; tick64 = 0; tickSec = 0; minRoll = 0; hourRoll = 0;
    end
  endtask

  task automatic wr(logic a, logic [DW-1:0] d);
    @(negedge clk); #1;
    wrEn = 1; regAddr = a; wrData = d;
    @(negedge clk); #1;
    wrEn = 0; regAddr = 1'b1;
  endtask

  task automatic strobe(int src);
    @(negedge clk); #1;
    tick64 = (src == 0); tickSec = (src == 1);
    minRoll = (src == 2); hourRoll = (src == 3);
    @(negedge clk); #1;
    tick64 = 0; tickSec = 0; minRoll = 0; hourRoll = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

  initial begin : stim
    curReq = "R1";
    idle(3);
    rstN = 1'b1;
    idle(3);

    // R2 / R3: each rate code against all four strobes
    for (int code = 0; code < 4; code++) begin
      curReq = "R2";
      wr(1'b0, DW'(code));
      wr(1'b1, 8'h00);
      for (int s = 0; s < 4; s++) begin
        if (s != code) strobe(s);
      end
      idle(2);
      curReq = "R3";
      strobe(code);
      idle(3);
      wr(1'b1, 8'h01);
      idle(2);
      wr(1'b1, 8'h00);
      idle(2);
    end

    // R4: clear together with a selected event
    curReq = "R4";
    wr(1'b0, 8'h01);
    @(negedge clk); #1;
    tickSec = 1; wrEn = 1; regAddr = 1'b1; wrData = 8'h00;
    idle(3);

    // R5: latched mode
    curReq = "R5";
    strobe(1);
    idle(4);
    wr(1'b1, 8'h00);
    idle(2);

    // R6: pulse mode, single and back-to-back events
    curReq = "R6";
    wr(1'b0, 8'h09);
    strobe(1);
    idle(5);
    strobe(1);
    strobe(1);
    idle(6);
    wr(1'b1, 8'h00);

    // R7: masked in both modes
    curReq = "R7";
    wr(1'b0, 8'h05);
    strobe(1);
    idle(3);
    wr(1'b0, 8'h0D);
    strobe(1);
    idle(4);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h01);

    // R8 / R9 / R10: adjust with seconds 45 (rounds up)
    curReq = "R10";
    cntReq = 1'b1;
    secCount = 6'd45;
    wr(1'b1, 8'h03);
    curReq = "R8";
    idle(ADJ + 4);
    curReq = "R9";
    idle(2);
    // seconds 12 (no carry)
    curReq = "R10";
    secCount = 6'd12;
    wr(1'b1, 8'h03);
    idle(ADJ + 4);
    // threshold cases
    secCount = 6'd30;
    wr(1'b1, 8'h03);
    idle(ADJ + 2);
    secCount = 6'd29;
    wr(1'b1, 8'h03);
    idle(ADJ + 2);

    // R12: second start during window
    curReq = "R12";
    secCount = 6'd50;
    wr(1'b1, 8'h03);
    idle(10);
    wr(1'b1, 8'h03);
    idle(ADJ + 4);

    // R11: oscillator stops during window
    curReq = "R11";
    wr(1'b1, 8'h03);
    idle(5);
    oscRun = 1'b0;
    idle(ADJ + 10);
    oscRun = 1'b1;
    idle(ADJ + 4);
    cntReq = 1'b0;

    // R1: reset mid-operation
    curReq = "R1";
    wr(1'b0, 8'h0B);
    strobe(3);
    wr(1'b1, 8'h03);
    rstN = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

endmodule